// File: doc/BRIEF.md
# Packet Byte Count Reload Controller

This block keeps track of a host data transfer that is delivered as a chain of packets. The microcontroller loads a 32-bit total of bytes still to move. A 16-bit packet size is held in a store. A 16-bit byte count tells the host how many bytes the current packet carries. Each byte that crosses the host interface pulses a transfer strobe, and the total and the byte count both drop by one on that pulse.

When the byte count reaches zero and bytes still remain, the block reloads the count by itself. It loads the stored packet size if enough bytes are left, and otherwise the smaller remainder. The packet size store can be written by the microcontroller. It also takes a copy of the byte count when the host writes a command while this drive is selected.

All counters are reached through a byte-wide register port with combinational readback. A status byte reports a sticky underrun flag and a done flag.

Top module: `pkt_count_ctrl`

## Requirements
- R1: After reset the total, the packet size store and the byte count are zero, and `done` and `underrun` are low.
- R2: Register offsets: 0 to 3 hold the total (offset 0 is the least significant byte), 4 and 5 hold the packet size (low byte at 4), 6 and 7 hold the byte count (low byte at 6), and 8 is status (bit 0 done, bit 1 underrun). A write is visible on `cpu_rdata` from the next cycle.
- R3: A transfer strobe is counted only when the byte count and the total are both nonzero and no counter byte is being written in that cycle. A counted strobe lowers each of them by one in the next cycle. Any other strobe leaves both unchanged.
- R4: When the byte count is zero, the total is nonzero and the total is at least the packet size (compared over the full 32 bits), the byte count is loaded with the packet size in the next cycle.
- R5: When the byte count is zero and the total is nonzero but smaller than the packet size, the byte count is loaded with the low 16 bits of the total.
- R6: A transfer strobe that arrives in a reload cycle is dropped, and the total keeps its value.
- R7: A host command write while `drive_sel` is high copies the byte count present in that cycle into the packet size store.
- R8: A host command write while `drive_sel` is low leaves the packet size store unchanged.
- R9: A microcontroller write to a counter byte (offsets 0 to 7) takes effect in the next cycle. It overrides a same-cycle decrement, reload or host capture, and no decrement or reload happens in that cycle.
- R10: A transfer strobe while the total and the byte count are both zero sets `underrun` and changes no counter. `underrun` stays set until the status offset is written with bit 1 set. A write with bit 1 clear leaves it set.
- R11: `done` rises in the cycle after a counted strobe brings the total to zero. It stays high until any byte of the total is written.
- R12: The reload repeats at every packet boundary, so a total T with a packet size P yields packets of P bytes followed by one packet of T mod P bytes when that is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Microcontroller register write strobe |
| cpu_addr | input | 4 | Register offset |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Combinational readback of the addressed register |
| host_cmd_wr | input | 1 | Host wrote the command register |
| drive_sel | input | 1 | This drive is the selected one |
| xfer_strobe | input | 1 | One byte transferred |
| byte_count | output | 16 | Current packet byte count |
| done | output | 1 | Total has been counted down to zero |
| underrun | output | 1 | Sticky: a strobe arrived with nothing left |

## Verification
The case that is hardest to reach is the exact cycle where the byte count has just hit zero with bytes still left. The reload happens there, and any strobe in that cycle must be lost. The bench reaches this cycle on purpose. It programs a zero byte count with a nonzero total through back-to-back register writes, so the writes hold off the reload until the last one ends, and then it raises the strobe on that very cycle. A sweep over small totals and packet sizes drives a burst of strobes for each packet. It then checks every reload value against the smaller of the packet size and the bytes remaining, which covers exact multiples, short tails and packets larger than the whole transfer.

// File: rtl/pkt_pkg.sv
package pkt_pkg;
  localparam int BYTE_W        = 8;
  localparam int STAT_DONE_BIT = 0;
  localparam int STAT_UNDR_BIT = 1;
endpackage

// File: rtl/pkt_total_ctr.sv
module pkt_total_ctr #(
  parameter int W      = 32,
  parameter int BYTE_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [W/BYTE_W-1:0]    lane_wr,
  input  logic [BYTE_W-1:0]      wdata,
  input  logic                   dec,
  output logic [W-1:0]           total,
  output logic                   done
);
  localparam int NB = W / BYTE_W;

  logic [W-1:0] q;
  logic         done_q;
  logic         any_wr;

  assign any_wr = |lane_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q      <= '0;
      done_q <= 1'b0;
    end else begin
      if (dec) q <= q - W'(1);
      for (int i = 0; i < NB; i++)
        if (lane_wr[i]) q[i*BYTE_W +: BYTE_W] <= wdata;
      if (any_wr)
        done_q <= 1'b0;
      else if (dec && q == W'(1))
        done_q <= 1'b1;
    end
  end

  assign total = q;
  assign done  = done_q;

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done && !any_wr |=> done); // R11
  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    any_wr |=> !done); // R11
endmodule

// File: rtl/pkt_size_store.sv
module pkt_size_store #(
  parameter int W      = 16,
  parameter int BYTE_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [W/BYTE_W-1:0]  lane_wr,
  input  logic [BYTE_W-1:0]    wdata,
  input  logic                 capture,
  input  logic [W-1:0]         cap_val,
  output logic [W-1:0]         pss
);
  localparam int NB = W / BYTE_W;

  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      if (capture) q <= cap_val;
      for (int i = 0; i < NB; i++)
        if (lane_wr[i]) q[i*BYTE_W +: BYTE_W] <= wdata;
    end
  end

  assign pss = q;

  AST_CAPTURE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    capture && !(|lane_wr) |=> pss == $past(cap_val)); // R7
  AST_SIZE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !capture && !(|lane_wr) |=> $stable(pss)); // R8
endmodule

// File: rtl/pkt_bcount.sv
module pkt_bcount #(
  parameter int W      = 16,
  parameter int BYTE_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [W/BYTE_W-1:0]  lane_wr,
  input  logic [BYTE_W-1:0]    wdata,
  input  logic                 dec,
  input  logic                 reload,
  input  logic [W-1:0]         reload_val,
  output logic [W-1:0]         count
);
  localparam int NB = W / BYTE_W;

  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      if (reload)   q <= reload_val;
      else if (dec) q <= q - W'(1);
      for (int i = 0; i < NB; i++)
        if (lane_wr[i]) q[i*BYTE_W +: BYTE_W] <= wdata;
    end
  end

  assign count = q;

  for (genvar g = 0; g < NB; g++) begin : g_lane_chk
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      lane_wr[g] |=> count[g*BYTE_W +: BYTE_W] == $past(wdata)); // R9
  end
endmodule

// File: rtl/pkt_count_ctrl.sv
module pkt_count_ctrl #(
  parameter int TOTAL_W = 32,
  parameter int PKT_W   = 16,
  parameter int ADDR_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_wr,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [pkt_pkg::BYTE_W-1:0] cpu_wdata,
  output logic [pkt_pkg::BYTE_W-1:0] cpu_rdata,
  input  logic                    host_cmd_wr,
  input  logic                    drive_sel,
  input  logic                    xfer_strobe,
  output logic [PKT_W-1:0]        byte_count,
  output logic                    done,
  output logic                    underrun
);
  import pkt_pkg::*;

  localparam int NB_T     = TOTAL_W / BYTE_W;
  localparam int NB_P     = PKT_W / BYTE_W;
  localparam int TOT_OFF  = 0;
  localparam int PSS_OFF  = TOT_OFF + NB_T;
  localparam int BC_OFF   = PSS_OFF + NB_P;
  localparam int STAT_OFF = BC_OFF + NB_P;

  function automatic logic [PKT_W-1:0] next_packet(
    input logic [TOTAL_W-1:0] left, input logic [PKT_W-1:0] size);
    if (left >= TOTAL_W'(size)) return size;
    return left[PKT_W-1:0];
  endfunction

  logic [NB_T-1:0]    tot_wr;
  logic [NB_P-1:0]    pss_wr;
  logic [NB_P-1:0]    bc_wr;
  logic               stat_wr;
  logic [TOTAL_W-1:0] total;
  logic [PKT_W-1:0]   pss;
  logic               counter_wr;
  logic               bc_zero, tot_zero;
  logic               ev_accept, ev_reload, ev_underrun, ev_capture;
  logic               undr_q;

  for (genvar g = 0; g < NB_T; g++) begin : g_tot_dec
    assign tot_wr[g] = cpu_wr && (cpu_addr == ADDR_W'(TOT_OFF + g));
  end
  for (genvar g = 0; g < NB_P; g++) begin : g_pkt_dec
    assign pss_wr[g] = cpu_wr && (cpu_addr == ADDR_W'(PSS_OFF + g));
    assign bc_wr[g]  = cpu_wr && (cpu_addr == ADDR_W'(BC_OFF + g));
  end
  assign stat_wr = cpu_wr && (cpu_addr == ADDR_W'(STAT_OFF));

  assign counter_wr  = (|tot_wr) | (|pss_wr) | (|bc_wr);
  assign bc_zero     = (byte_count == '0);
  assign tot_zero    = (total == '0);
  assign ev_reload   = bc_zero && !tot_zero && !counter_wr;
  assign ev_accept   = xfer_strobe && !bc_zero && !tot_zero && !counter_wr;
  assign ev_underrun = xfer_strobe && bc_zero && tot_zero;
  assign ev_capture  = host_cmd_wr && drive_sel;

  pkt_total_ctr #(.W(TOTAL_W), .BYTE_W(BYTE_W)) u_total (
    .clk(clk), .rst_n(rst_n), .lane_wr(tot_wr), .wdata(cpu_wdata),
    .dec(ev_accept), .total(total), .done(done));

  pkt_size_store #(.W(PKT_W), .BYTE_W(BYTE_W)) u_size (
    .clk(clk), .rst_n(rst_n), .lane_wr(pss_wr), .wdata(cpu_wdata),
    .capture(ev_capture), .cap_val(byte_count), .pss(pss));

  pkt_bcount #(.W(PKT_W), .BYTE_W(BYTE_W)) u_bcount (
    .clk(clk), .rst_n(rst_n), .lane_wr(bc_wr), .wdata(cpu_wdata),
    .dec(ev_accept), .reload(ev_reload),
    .reload_val(next_packet(total, pss)), .count(byte_count));

  always_ff @(posedge clk) begin
    if (!rst_n)                                undr_q <= 1'b0;
    else if (ev_underrun)                      undr_q <= 1'b1;
    else if (stat_wr && cpu_wdata[STAT_UNDR_BIT]) undr_q <= 1'b0;
  end
  assign underrun = undr_q;

  always_comb begin
    cpu_rdata = '0;
    for (int i = 0; i < NB_T; i++)
      if (cpu_addr == ADDR_W'(TOT_OFF + i)) cpu_rdata = total[i*BYTE_W +: BYTE_W];
    for (int i = 0; i < NB_P; i++) begin
      if (cpu_addr == ADDR_W'(PSS_OFF + i)) cpu_rdata = pss[i*BYTE_W +: BYTE_W];
      if (cpu_addr == ADDR_W'(BC_OFF + i))  cpu_rdata = byte_count[i*BYTE_W +: BYTE_W];
    end
    if (cpu_addr == ADDR_W'(STAT_OFF)) begin
      cpu_rdata[STAT_DONE_BIT] = done;
      cpu_rdata[STAT_UNDR_BIT] = undr_q;
    end
  end

  AST_LOCKSTEP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> total == $past(total) - TOTAL_W'(1)
               && byte_count == $past(byte_count) - PKT_W'(1)); // R3
  AST_RELOAD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reload && total >= TOTAL_W'(pss) |=> byte_count == $past(pss)); // R4
  AST_RELOAD_REM: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reload && total < TOTAL_W'(pss) |=> byte_count == $past(total[PKT_W-1:0])); // R5
  AST_RELOAD_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reload |=> $stable(total)); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ev_underrun |=> underrun && total == '0 && byte_count == '0); // R10
  AST_UNDR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    underrun && !stat_wr |=> underrun); // R10
endmodule

// File: tb/pkt_count_ctrl_tb.sv
`timescale 1ns/1ps
module pkt_count_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_wr;
  logic [3:0]  cpu_addr;
  logic [7:0]  cpu_wdata;
  logic [7:0]  cpu_rdata;
  logic        host_cmd_wr, drive_sel, xfer_strobe;
  logic [15:0] byte_count;
  logic        done, underrun;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pkt_count_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .host_cmd_wr(host_cmd_wr),
    .drive_sel(drive_sel), .xfer_strobe(xfer_strobe), .byte_count(byte_count),
    .done(done), .underrun(underrun));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    cpu_addr = a; #1; d = cpu_rdata;
  endtask

  task automatic rd_total(output logic [31:0] v);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      rd(4'(i), b); v[i*8 +: 8] = b;
    end
  endtask

  task automatic rd_size(output logic [15:0] v);
    logic [7:0] b;
    rd(4'd4, b); v[7:0] = b;
    rd(4'd5, b); v[15:8] = b;
  endtask

  task automatic set_all(input logic [31:0] t, input logic [15:0] p, input logic [15:0] c);
    wr(4'd4, p[7:0]);  wr(4'd5, p[15:8]);
    wr(4'd6, c[7:0]);  wr(4'd7, c[15:8]);
    for (int i = 0; i < 4; i++) wr(4'(i), t[i*8 +: 8]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] t32;
    logic [15:0] s16;
    logic [7:0]  b;
    rst_n = 1'b0; cpu_wr = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    host_cmd_wr = 1'b0; drive_sel = 1'b0; xfer_strobe = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 count", 32'(byte_count), 0);
    check("R1 done", 32'(done), 0);
    check("R1 underrun", 32'(underrun), 0);
    rd_total(t32); check("R1 total", t32, 0);
    rd_size(s16);  check("R1 size", 32'(s16), 0);

    // R2 register map and readback
    set_all(32'h89AB_CDEF, 16'h1234, 16'h5678);
    for (int i = 0; i < 8; i++) begin
      logic [7:0] exp_b;
      case (i)
        0: exp_b = 8'hEF; 1: exp_b = 8'hCD; 2: exp_b = 8'hAB; 3: exp_b = 8'h89;
        4: exp_b = 8'h34; 5: exp_b = 8'h12; 6: exp_b = 8'h78; default: exp_b = 8'h56;
      endcase
      rd(4'(i), b); check("R2 readback", 32'(b), 32'(exp_b));
    end
    check("R2 count port", 32'(byte_count), 32'h5678);

    // R9 write beats a same-cycle strobe
    xfer_strobe = 1'b1;
    wr(4'd6, 8'h00);
    xfer_strobe = 1'b0;
    check("R9 count written", 32'(byte_count), 32'h5600);
    rd_total(t32); check("R9 total held", t32, 32'h89AB_CDEF);

    // R3 one counted strobe
    xfer_strobe = 1'b1; @(negedge clk); xfer_strobe = 1'b0;
    check("R3 count dec", 32'(byte_count), 32'h55FF);
    rd_total(t32); check("R3 total dec", t32, 32'h89AB_CDEE);

    // R8 capture ignored without drive select
    host_cmd_wr = 1'b1; drive_sel = 1'b0; @(negedge clk); host_cmd_wr = 1'b0;
    rd_size(s16); check("R8 size kept", 32'(s16), 32'h1234);
    // R7 capture with drive select
    host_cmd_wr = 1'b1; drive_sel = 1'b1; @(negedge clk); host_cmd_wr = 1'b0;
    rd_size(s16); check("R7 size captured", 32'(s16), 32'h55FF);
    // R9 size write beats capture
    host_cmd_wr = 1'b1;
    wr(4'd4, 8'h11);
    host_cmd_wr = 1'b0; drive_sel = 1'b0;
    rd_size(s16); check("R9 size write wins", 32'(s16), 32'h5511);

    // R4 full-width compare, R6 strobe dropped in reload cycle
    set_all(32'h0001_0003, 16'h0010, 16'h0000);
    xfer_strobe = 1'b1; @(negedge clk); xfer_strobe = 1'b0;
    check("R4 wide reload", 32'(byte_count), 32'h0010);
    rd_total(t32); check("R6 strobe dropped", t32, 32'h0001_0003);

    // R5 remainder smaller than size
    set_all(32'h0000_0007, 16'h0100, 16'h0000);
    @(negedge clk);
    check("R5 remainder reload", 32'(byte_count), 32'h0007);

    // R3 strobe ignored when total is zero but count is not
    set_all(32'h0, 16'h0004, 16'h0005);
    xfer_strobe = 1'b1; @(negedge clk); xfer_strobe = 1'b0;
    check("R3 ignored count", 32'(byte_count), 32'h0005);
    check("R3 ignored underrun", 32'(underrun), 0);

    // R10 underrun
    wr(4'd6, 8'h00);
    xfer_strobe = 1'b1; @(negedge clk); xfer_strobe = 1'b0;
    check("R10 underrun set", 32'(underrun), 1);
    rd_total(t32); check("R10 total kept", t32, 0);
    check("R10 count kept", 32'(byte_count), 0);
    @(negedge clk);
    check("R10 sticky", 32'(underrun), 1);
    wr(4'd8, 8'h01);
    check("R10 bit1 clear no effect", 32'(underrun), 1);
    wr(4'd8, 8'h02);
    check("R10 cleared", 32'(underrun), 0);

    // R12 / R4 / R5 sweep over small totals and sizes
    for (int t = 1; t <= 40; t++) begin
      for (int p = 1; p <= 9; p++) begin
        int rem;
        set_all(32'(t), 16'(p), 16'h0000);
        check("R11 done cleared by write", 32'(done), 0);
        @(negedge clk);
        rem = t;
        while (rem > 0) begin
          int exp_pkt;
          exp_pkt = (p <= rem) ? p : rem;
          if (p <= rem) check("R4 reload size", 32'(byte_count), 32'(exp_pkt));
          else          check("R5 reload remainder", 32'(byte_count), 32'(exp_pkt));
          xfer_strobe = 1'b1;
          repeat (exp_pkt) @(negedge clk);
          xfer_strobe = 1'b0;
          rem -= exp_pkt;
          rd_total(t32); check("R12 total after packet", t32, 32'(rem));
          check("R12 count at boundary", 32'(byte_count), 0);
          if (rem > 0) @(negedge clk);
        end
        check("R11 done set", 32'(done), 1);
      end
    end

    // R11 done holds while idle, clears on a total write
    repeat (3) @(negedge clk);
    check("R11 done holds", 32'(done), 1);
    wr(4'd2, 8'h00);
    check("R11 done cleared", 32'(done), 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule